// File: doc/BRIEF.md
# Multi-Mode Countdown Timer with Watchdog

This block is a single 16-bit down-counter behind a small 32-bit register bus. A prescaler divides the clock by a power of two between 1 and 32768, and each prescaled tick moves the count one step toward zero. What happens when the count reaches zero depends on a 2-bit mode field. The counter can wrap and keep going. It can reload and raise an interrupt. It can raise one interrupt and stop. In watchdog mode it asks the system to reset.

Software follows a fixed order. It first writes mode and prescale with the enable bit clear. It then writes the reload value. Finally it sets the enable bit in a separate write. In watchdog mode, every later write of the reload value is the keep-alive kick. A watchdog expiry sets a sticky flag. After the restart, software reads that flag to learn why the system was reset.

Top module: `mode_timer`

## Requirements
- R1: After reset, reads at offsets 0x00, 0x04 and 0x08 all return 0, and `irq` and `sys_rst_req` are low.
- R2: While control bit 7 (enable) is 0, the counter value does not change except through a reload write.
- R3: A write to offset 0x00 stores bits 15:0 as the reload value and places it in the counter at the same clock edge. A read of offset 0x00 returns the current counter value in bits 15:0.
- R4: Prescale code n (control bits 3:0) gives one tick every 2^n enabled cycles. Counting from the edge that loads value L or sets enable, expiry happens at the tick (L+1)*2^n cycles later. The registered event output is high in the cycle that follows that edge.
- R5: Mode 0 (control bits 5:4 = 0) is free-running. A tick at count 0 wraps the counter to 0xFFFF, and no interrupt and no reset request are raised.
- R6: Mode 1 is periodic. Each expiry reloads the counter from the reload value and gives a one-cycle `irq` pulse. `irq` is never raised in mode 0 or mode 3.
- R7: Mode 2 is one-shot. The first expiry gives a single `irq` pulse. The counter then holds at 0 with no further pulses until a reload or control write.
- R8: Mode 3 is watchdog. Expiry gives a one-cycle `sys_rst_req` pulse instead of `irq`, and the counter reloads from the reload value.
- R9: In watchdog mode, a write to offset 0x00 before expiry restarts the full countdown, and no reset request is raised.
- R10: Status bit 1 at offset 0x04 sets on every watchdog expiry. Writing 1 to that bit clears it. Writing 0 to it, or any other write, leaves it set.
- R11: Clearing enable freezes the count. Setting enable again resumes from the frozen value with the prescaler restarted from zero.
- R12: Offset 0x08 reads back enable in bit 7, mode in bits 5:4 and prescale code in bits 3:0, with other bits 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 4 | Byte offset of the register accessed |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | One-cycle expiry pulse in periodic and one-shot modes |
| sys_rst_req | output | 1 | One-cycle reset request on watchdog expiry |

## Verification
The embedded properties check on every cycle the rules that hold cycle by cycle:
- the count stays fixed while the counter is disabled;
- a reload write lands in the counter at once;
- `irq` and `sys_rst_req` appear only in their own modes;
- each reset request leaves the sticky flag set;
- the flag falls only after a write of 1;
- a finished one-shot holds at zero.

Other behaviours need whole scenarios, so only the bench can show them. These are the exact expiry cycle for each prescale code, the wrap to 0xFFFF and the resume after a freeze. They also include the way kicks postpone a watchdog reset. The bench predicts each event cycle and compares it against what the design produces.

// File: rtl/mode_timer.sv
module mode_timer #(
  parameter int CNT_W    = 16,
  parameter int PSC_W    = 4,
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 32,
  parameter int LOAD_OFS = 0,
  parameter int STAT_OFS = 4,
  parameter int CTRL_OFS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq,
  output logic              sys_rst_req
);
  localparam int PRE_W = (1 << PSC_W) - 1;
  localparam logic [1:0] M_FREE = 2'd0, M_PER = 2'd1, M_ONE = 2'd2, M_WDOG = 2'd3;

  logic [CNT_W-1:0] load_q, cnt_q;
  logic             en_q, done_q, wflag_q, irq_q, rst_q;
  logic [1:0]       mode_q;
  logic [PSC_W-1:0] psc_q;
  logic [PRE_W-1:0] pre_q, pre_mask;

  wire load_wr = bus_we && (bus_addr == ADDR_W'(LOAD_OFS));
  wire stat_wr = bus_we && (bus_addr == ADDR_W'(STAT_OFS));
  wire ctrl_wr = bus_we && (bus_addr == ADDR_W'(CTRL_OFS));
  wire en_rise = ctrl_wr && bus_wdata[7] && !en_q;

  assign pre_mask = PRE_W'((64'd1 << psc_q) - 64'd1);
  wire tick   = en_q && ((pre_q & pre_mask) == pre_mask);
  wire expire = tick && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      mode_q <= M_FREE;
      psc_q  <= '0;
      pre_q  <= '0;
    end else begin
      if (ctrl_wr) begin
        en_q   <= bus_wdata[7];
        mode_q <= bus_wdata[5:4];
        psc_q  <= bus_wdata[PSC_W-1:0];
      end
      if (load_wr || en_rise) pre_q <= '0;
      else if (en_q)          pre_q <= pre_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_q  <= '0;
      cnt_q   <= '0;
      done_q  <= 1'b0;
      wflag_q <= 1'b0;
      irq_q   <= 1'b0;
      rst_q   <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      rst_q <= 1'b0;
      if (stat_wr && bus_wdata[1]) wflag_q <= 1'b0;
      if (ctrl_wr) done_q <= 1'b0;
      if (load_wr) begin
        load_q <= bus_wdata[CNT_W-1:0];
        cnt_q  <= bus_wdata[CNT_W-1:0];
        done_q <= 1'b0;
      end else if (expire) begin
        case (mode_q)
          M_FREE: cnt_q <= '1;
          M_PER: begin
            cnt_q <= load_q;
            irq_q <= 1'b1;
          end
          M_ONE: begin
            if (!done_q) irq_q <= 1'b1;
            done_q <= 1'b1;
          end
          default: begin
            cnt_q   <= load_q;
            rst_q   <= 1'b1;
            wflag_q <= 1'b1;
          end
        endcase
      end else if (tick) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign irq         = irq_q;
  assign sys_rst_req = rst_q;

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(LOAD_OFS))      bus_rdata = DATA_W'(cnt_q);
    else if (bus_addr == ADDR_W'(STAT_OFS)) bus_rdata = DATA_W'({wflag_q, 1'b0});
    else if (bus_addr == ADDR_W'(CTRL_OFS)) bus_rdata = DATA_W'({en_q, 1'b0, mode_q, psc_q});
  end

  p_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !load_wr) |=> $stable(cnt_q));
  p_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load_wr |=> (cnt_q == $past(bus_wdata[CNT_W-1:0])));
  p_irq_mode_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ($past(mode_q) == M_PER || $past(mode_q) == M_ONE));
  p_oneshot_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_ONE && done_q && !load_wr && !ctrl_wr) |=> (cnt_q == '0 && !irq));
  p_rst_mode_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_req |-> ($past(mode_q) == M_WDOG));
  p_flag_on_rst_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_req |-> wflag_q);
  p_flag_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wflag_q) |-> $past(stat_wr && bus_wdata[1]));
endmodule

// File: tb/test_mode_timer.sv
module test_mode_timer;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0, bus_we = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq, sys_rst_req;

  mode_timer i_mode_timer (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .sys_rst_req(sys_rst_req)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct { int cyc; bit rst; string tag; } evt_t;
  evt_t exp_q[$];
  int cyc = 0, n_chk = 0, n_fail = 0, last_wr = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && (irq || sys_rst_req)) begin
    evt_t e;
    n_chk++;
    if (exp_q.size() == 0) begin
      n_fail++;
      $display("FAIL R6/R8 unexpected event: got irq=%0b rst=%0b at %0d expected none", irq, sys_rst_req, cyc);
    end else begin
      e = exp_q.pop_front();
      if (e.cyc != cyc || e.rst != sys_rst_req || e.rst == irq) begin
        n_fail++;
        $display("FAIL %s event: got cycle %0d rst=%0b expected cycle %0d rst=%0b", e.tag, cyc, sys_rst_req, e.cyc, e.rst);
      end
    end
  end

  task automatic wr(logic [3:0] a, logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    last_wr = cyc;
    bus_we = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic wait_cyc(int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic push(int c, bit r, string tag);
    evt_t e;
    e.cyc = c; e.rst = r; e.tag = tag;
    exp_q.push_back(e);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_fail++;
    $display("FAIL watchdog: got hang expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail + 1, n_chk + 1);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int e;
    repeat (3) @(negedge clk);
    rd(4'h0, d); check("R1 count", d, 0);
    rd(4'h4, d); check("R1 status", d, 0);
    rd(4'h8, d); check("R1 control", d, 0);
    check("R1 outputs", {30'd0, irq, sys_rst_req}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    wr(4'h8, 32'h12);
    rd(4'h8, d); check("R12 control layout", d, 32'h12);
    wr(4'h0, 5);
    rd(4'h0, d); check("R3 reload read", d, 5);
    repeat (10) @(negedge clk);
    rd(4'h0, d); check("R2 frozen while disabled", d, 5);

    wr(4'h8, 32'h92); e = last_wr;
    rd(4'h8, d); check("R12 enable bit", d, 32'h92);
    push(e + 24, 0, "R4/R6"); push(e + 48, 0, "R6"); push(e + 72, 0, "R6");
    wait_cyc(e + 10);
    rd(4'h0, d); check("R4 count after 10 cycles at div 4", d, 3);
    wait_cyc(e + 80);
    wr(4'h8, 32'h12);
    repeat (20) @(negedge clk);
    rd(4'h0, d); check("R11 frozen value", d, 3);
    wr(4'h8, 32'h92); e = last_wr;
    push(e + 16, 0, "R11 resume");
    wait_cyc(e + 20);
    wr(4'h8, 32'h12);

    wr(4'h8, 32'h00);
    wr(4'h0, 3);
    wr(4'h8, 32'h80); e = last_wr;
    wait_cyc(e + 4);
    rd(4'h0, d); check("R5 wrap", d, 32'hFFFF);
    wait_cyc(e + 6);
    rd(4'h0, d); check("R5 continues", d, 32'hFFFD);
    wr(4'h8, 32'h00);

    wr(4'h8, 32'h21);
    wr(4'h0, 3);
    wr(4'h8, 32'hA1); e = last_wr;
    push(e + 8, 0, "R4/R7");
    wait_cyc(e + 40);
    rd(4'h0, d); check("R7 holds at zero", d, 0);
    check("R7 single pulse", exp_q.size(), 0);
    wr(4'h8, 32'h21);

    wr(4'h8, 32'h30);
    wr(4'h0, 10);
    wr(4'h8, 32'hB0); e = last_wr;
    for (int k = 0; k < 3; k++) begin
      wait_cyc(e + 8);
      wr(4'h0, 10); e = last_wr;
      rd(4'h0, d); check("R9 kick reloads", d, 10);
    end
    rd(4'h4, d); check("R9 no flag after kicks", d, 0);
    push(e + 11, 1, "R8");
    wait_cyc(e + 13);
    wr(4'h8, 32'h30);
    rd(4'h4, d); check("R10 flag set", d, 2);
    wr(4'h4, 0);
    rd(4'h4, d); check("R10 write 0 keeps", d, 2);
    wr(4'h4, 2);
    rd(4'h4, d); check("R10 write 1 clears", d, 0);

    repeat (5) @(negedge clk);
    check("R6/R8 all events seen", exp_q.size(), 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule